// File: doc/BRIEF.md
# Sampled On/Off Switch Gate Controller

This block decides, one switching cycle at a time, whether a power switch is turned on. The oscillator supplies a one-clock cycle-start pulse and a maximum-duty window. The feedback loop supplies a digital enable level. The controller reads that level only at the cycle-start pulse. An enabled cycle turns the gate on. A disabled cycle leaves the gate off for the whole period. Output regulation therefore comes from skipping whole cycles, not from changing the pulse width.

Once the gate is on, it is turned off by whichever comes first: the end of the max-duty window, or a current-limit comparator flag. The current-limit flag only counts once a blanking interval has passed after turn-on. Two lockouts sit above this logic, and each has hysteresis. The supply lockout is set by a below-low flag and cleared by an above-high flag. It starts out set after reset. The thermal lockout is set by an over-hot flag and cleared by a cooled flag. Either lockout pulls the gate low at the next clock and blocks all later cycle-start sampling until it clears.

Top module: `onoff_switch_ctrl`

## Requirements
- R1: After reset, `gate_o`=0, `uv_lock_o`=1, `ot_lock_o`=0, `cyc_en_o`=0 and `ilim_trip_o`=0.
- R2: When `cyc_start_i`=1 at a clock edge with `fb_en_i`=1, `max_duty_i`=1 and no lockout active or being set, `gate_o` is 1 after that edge and `cyc_en_o` is 1.
- R3: When `fb_en_i`=0 at a cycle-start edge, `gate_o` stays 0 until the next cycle start, whatever `fb_en_i` does in between. The gate never rises at an edge without `cyc_start_i`=1.
- R4: With `BLANK_CYC`=N, `ilim_i` is ignored during the first N clocks in which `gate_o` is 1. In any later gate-high clock, `ilim_i`=1 drives `gate_o` to 0 at the next edge and sets `ilim_trip_o`. The gate stays off until the next cycle start.
- R5: `max_duty_i`=0 in a clock where `gate_o` is 1 drives `gate_o` to 0 at the next edge.
- R6: `sup_low_i`=1 sets `uv_lock_o` and forces `gate_o` to 0 at the next edge. `uv_lock_o` stays set until `sup_high_i`=1 (the set flag wins if both are 1).
- R7: `temp_hot_i`=1 sets `ot_lock_o` and forces `gate_o` to 0 at the next edge. `ot_lock_o` stays set until `temp_cool_i`=1 (the set flag wins if both are 1).
- R8: A cycle start seen while a lockout is active leaves `gate_o`=0 and `cyc_en_o`=0.
- R9: Every cycle start clears `ilim_trip_o`. `cyc_en_o` holds the sampled enable decision of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | One-clock pulse at the start of each switching cycle |
| max_duty_i | input | 1 | High while on-time is permitted in the current cycle |
| fb_en_i | input | 1 | Feedback enable level, sampled at cycle start |
| ilim_i | input | 1 | Current-limit comparator flag |
| sup_low_i | input | 1 | Supply below the low threshold |
| sup_high_i | input | 1 | Supply above the high threshold |
| temp_hot_i | input | 1 | Die temperature above the trip threshold |
| temp_cool_i | input | 1 | Die temperature below the recovery threshold |
| gate_o | output | 1 | Power switch gate drive |
| uv_lock_o | output | 1 | Supply lockout active |
| ot_lock_o | output | 1 | Thermal lockout active |
| cyc_en_o | output | 1 | Current cycle was sampled as enabled |
| ilim_trip_o | output | 1 | Current cycle ended by the current limit |

## Verification
The bench goes first after the blanking boundary. It holds the current-limit flag high from turn-on and expects exactly N+1 gate-high clocks. An off-by-one timer would produce N or N+2, and a design with no blanking would produce a single clock. It also checks the hysteresis band: with neither supply flag asserted, the lockout must keep its state. A plain comparator would release early, or would start unlocked out of reset. Feedback toggling in mid-cycle is checked for any turn-on outside a cycle start. A lockout flag that arrives on the same edge as a cycle start must still block that cycle.

// File: rtl/onoff_switch_pkg.sv
package onoff_switch_pkg;

    typedef struct packed {
        logic gate;
        logic cyc_en;
        logic trip;
    } sw_state_t;

    typedef struct packed {
        logic locked;
    } lock_state_t;

endpackage

// File: rtl/hyst_lockout.sv
module hyst_lockout
    import onoff_switch_pkg::*;
#(
    parameter logic RESET_LOCKED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_next_o,
    output logic lock_o
);

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.locked = 1'b1;
        end else if (clr_i) begin
            st_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= RESET_LOCKED;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_next_o = st_d.locked;
    assign lock_o      = st_q.locked;

endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
    parameter int unsigned BLANK_CYC = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/onoff_switch_ctrl.sv
module onoff_switch_ctrl
    import onoff_switch_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic max_duty_i,
    input  logic fb_en_i,
    input  logic ilim_i,
    input  logic sup_low_i,
    input  logic sup_high_i,
    input  logic temp_hot_i,
    input  logic temp_cool_i,
    output logic gate_o,
    output logic uv_lock_o,
    output logic ot_lock_o,
    output logic cyc_en_o,
    output logic ilim_trip_o
);

    localparam int unsigned N_LOCK = 2;

    logic [N_LOCK-1:0] lk_set, lk_clr, lk_next, lk_q;
    logic lock_next;
    logic blank_done;
    logic turn_on;
    sw_state_t st_d, st_q;

    assign lk_set = {temp_hot_i, sup_low_i};
    assign lk_clr = {temp_cool_i, sup_high_i};

    // index 0: supply lockout (starts locked), index 1: thermal lockout
    generate
        for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
            hyst_lockout #(
                .RESET_LOCKED((g == 0) ? 1'b1 : 1'b0)
            ) u_lock (
                .clk         (clk),
                .rst_n       (rst_n),
                .set_i       (lk_set[g]),
                .clr_i       (lk_clr[g]),
                .lock_next_o (lk_next[g]),
                .lock_o      (lk_q[g])
            );
        end
    endgenerate

    assign lock_next = |lk_next;
    assign turn_on   = cyc_start_i && fb_en_i && max_duty_i && !lock_next;

    blank_timer #(
        .BLANK_CYC(BLANK_CYC)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (turn_on),
        .run_i     (st_q.gate),
        .expired_o (blank_done)
    );

    always_comb begin
        st_d = st_q;
        if (cyc_start_i) begin
            st_d.gate   = turn_on;
            st_d.cyc_en = turn_on;
            st_d.trip   = 1'b0;
        end else if (st_q.gate) begin
            if (!max_duty_i) begin
                st_d.gate = 1'b0;
            end else if (ilim_i && blank_done) begin
                st_d.gate = 1'b0;
                st_d.trip = 1'b1;
            end
        end
        if (lock_next) begin
            st_d.gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o      = st_q.gate;
    assign cyc_en_o    = st_q.cyc_en;
    assign ilim_trip_o = st_q.trip;
    assign uv_lock_o   = lk_q[0];
    assign ot_lock_o   = lk_q[1];

endmodule

// File: rtl/onoff_switch_checker.sv
module onoff_switch_checker (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_i,
    input logic max_duty_i,
    input logic fb_en_i,
    input logic sup_high_i,
    input logic temp_hot_i,
    input logic gate_o,
    input logic uv_lock_o,
    input logic ot_lock_o,
    input logic ilim_trip_o
);

    AST_LOCK_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lock_o || ot_lock_o) |-> !gate_o); // R6

    AST_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(cyc_start_i && fb_en_i)); // R3

    AST_TRIP_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ilim_trip_o) |-> !gate_o); // R4

    AST_MAXDUTY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && !max_duty_i) |=> !gate_o); // R5

    AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lock_o && !sup_high_i) |=> uv_lock_o); // R6

    AST_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot_i |=> ot_lock_o); // R7

endmodule

bind onoff_switch_ctrl onoff_switch_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .max_duty_i  (max_duty_i),
    .fb_en_i     (fb_en_i),
    .sup_high_i  (sup_high_i),
    .temp_hot_i  (temp_hot_i),
    .gate_o      (gate_o),
    .uv_lock_o   (uv_lock_o),
    .ot_lock_o   (ot_lock_o),
    .ilim_trip_o (ilim_trip_o)
);

// File: tb/tb_onoff_switch_ctrl.sv
`timescale 1ns/100ps
module tb_onoff_switch_ctrl;

    localparam int BLANK = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start_i = 0, max_duty_i = 0, fb_en_i = 0, ilim_i = 0;
    logic sup_low_i = 0, sup_high_i = 0, temp_hot_i = 0, temp_cool_i = 0;
    logic gate_o, uv_lock_o, ot_lock_o, cyc_en_o, ilim_trip_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_uv, m_ot, m_gate, m_en, m_trip;
    int m_blank;

    always #2.5 clk = ~clk;

    onoff_switch_ctrl #(.BLANK_CYC(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .max_duty_i(max_duty_i),
        .fb_en_i(fb_en_i), .ilim_i(ilim_i), .sup_low_i(sup_low_i), .sup_high_i(sup_high_i),
        .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i), .gate_o(gate_o),
        .uv_lock_o(uv_lock_o), .ot_lock_o(ot_lock_o), .cyc_en_o(cyc_en_o),
        .ilim_trip_o(ilim_trip_o)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_uv = 1; m_ot = 0; m_gate = 0; m_en = 0; m_trip = 0; m_blank = 0;
    endfunction

    // next state from the requirements, using inputs present at the edge
    function automatic void model_step();
        bit uv_n, ot_n, lk, g_n, en_n, tr_n, on;
        int b_n;
        uv_n = sup_low_i ? 1'b1 : (sup_high_i ? 1'b0 : m_uv);   // R6
        ot_n = temp_hot_i ? 1'b1 : (temp_cool_i ? 1'b0 : m_ot);  // R7
        lk = uv_n | ot_n;
        g_n = m_gate; en_n = m_en; tr_n = m_trip;
        on = cyc_start_i & fb_en_i & max_duty_i & !lk;
        if (cyc_start_i) begin
            g_n = on; en_n = on; tr_n = 0;                        // R2 R8 R9
        end else if (m_gate) begin
            if (!max_duty_i) g_n = 0;                             // R5
            else if (ilim_i && m_blank == 0) begin g_n = 0; tr_n = 1; end // R4
        end
        if (lk) g_n = 0;
        b_n = m_blank;
        if (on) b_n = BLANK;
        else if (m_gate && m_blank > 0) b_n = m_blank - 1;
        m_uv = uv_n; m_ot = ot_n; m_gate = g_n; m_en = en_n; m_trip = tr_n; m_blank = b_n;
    endfunction

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        #1;
        check({tag, " gate"}, gate_o, m_gate);
        check("R6 uv_lock", uv_lock_o, m_uv);
        check("R7 ot_lock", ot_lock_o, m_ot);
        check("R9 cyc_en", cyc_en_o, m_en);
        check("R4 trip", ilim_trip_o, m_trip);
    endtask

    task automatic clear_inputs();
        cyc_start_i = 0; max_duty_i = 0; fb_en_i = 0; ilim_i = 0;
        sup_low_i = 0; sup_high_i = 0; temp_hot_i = 0; temp_cool_i = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int gate_cnt;
        int period;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset gate", gate_o, 1'b0);
        check("R1 reset uv", uv_lock_o, 1'b1);
        check("R1 reset ot", ot_lock_o, 1'b0);
        check("R1 reset en", cyc_en_o, 1'b0);
        check("R1 reset trip", ilim_trip_o, 1'b0);
        rst_n = 1;

        // R8: cycle start while still locked from reset
        max_duty_i = 1; fb_en_i = 1; cyc_start_i = 1;
        step("R8 locked start");
        cyc_start_i = 0;
        step("R8 locked start");
        check("R8 gate blocked", gate_o, 1'b0);
        // R6: hysteresis band holds the lock
        repeat (3) step("R6 band");
        check("R6 band hold", uv_lock_o, 1'b1);
        sup_high_i = 1;
        step("R6 release");
        sup_high_i = 0;
        check("R6 released", uv_lock_o, 1'b0);

        // R4: blanking boundary with current limit held from turn-on
        ilim_i = 1; cyc_start_i = 1;
        step("R2 turn on");
        check("R2 gate on", gate_o, 1'b1);
        cyc_start_i = 0;
        gate_cnt = 0;
        for (int i = 0; i < BLANK + 5; i++) begin
            if (gate_o) gate_cnt++;
            step("R4 blank");
        end
        check_int("R4 gate-high clocks", gate_cnt, BLANK + 1);
        check("R4 trip flag", ilim_trip_o, 1'b1);
        ilim_i = 0;
        cyc_start_i = 1;
        step("R9 new cycle");
        cyc_start_i = 0;
        check("R9 trip cleared", ilim_trip_o, 1'b0);

        // R3: disabled cycle, feedback toggles mid-cycle
        repeat (4) step("R5 run");
        max_duty_i = 0;
        step("R5 duty end");
        check("R5 gate off", gate_o, 1'b0);
        max_duty_i = 1; fb_en_i = 0; cyc_start_i = 1;
        step("R3 disabled");
        cyc_start_i = 0; fb_en_i = 1;
        repeat (6) begin
            step("R3 ignore fb");
            check("R3 gate stays off", gate_o, 1'b0);
        end

        // R7: thermal lock on the same edge as a cycle start
        temp_hot_i = 1; cyc_start_i = 1;
        step("R7 hot start");
        temp_hot_i = 0; cyc_start_i = 0;
        check("R7 blocked", gate_o, 1'b0);
        check("R8 en low", cyc_en_o, 1'b0);
        temp_cool_i = 1;
        step("R7 cool");
        temp_cool_i = 0;

        // random cycles
        for (int c = 0; c < 300; c++) begin
            period = 20 + int'($urandom_range(0, 20));
            fb_en_i = $urandom_range(0, 3) != 0;
            for (int k = 0; k < period; k++) begin
                cyc_start_i = (k == 0);
                max_duty_i  = (k < period - 4);
                if ($urandom_range(0, 9) == 0) fb_en_i = ~fb_en_i;
                ilim_i      = ($urandom_range(0, 15) == 0);
                sup_low_i   = ($urandom_range(0, 199) == 0);
                sup_high_i  = ($urandom_range(0, 19) == 0);
                temp_hot_i  = ($urandom_range(0, 299) == 0);
                temp_cool_i = ($urandom_range(0, 19) == 0);
                step("R2/R3/R4/R5 random");
            end
        end
        clear_inputs();
        step("R1 idle");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule